// File: doc/BRIEF.md
# 8-bit Accumulator Fetch-Decode Core

This block is a small sequential processor core for an 8-bit accumulator machine. It runs a narrow part of the instruction set. It fetches a one-byte opcode from the address held in its 16-bit program counter. It splits that opcode into an operation field, an addressing-mode field and a group field. It then fetches whatever operand bytes the decoded instruction needs and carries the instruction out before fetching the next one. The supported instructions are:

- accumulator load with an inline (immediate) operand;
- accumulator load from a page-zero memory location;
- an absolute jump.

Any other opcode counts as a one-byte no-operation. For each one the core raises a single-cycle `illegal_op` pulse.

The core has one byte-wide synchronous memory port. When `mem_rd` is high in a cycle, memory returns the byte at `mem_addr` on `mem_rdata` in the following cycle. The accumulator is brought straight out as a port. After a load, the program counter moves on by the instruction's length, which comes from its addressing mode. A jump writes the program counter directly, so no length-based step is added.

Top module: `cpu8_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `acc` is 0x00, `illegal_op` is low, and the core drives `mem_rd` high with `mem_addr` equal to the parameter `RESET_PC` (default 0x0200). This is the opcode fetch of the first instruction.
- R2: The opcode byte is decoded as operation = bits [7:5], mode = bits [4:2] and group = bits [1:0]. Operation 101 in group 01 is a load. Mode 010 (0xA9) is immediate and mode 001 (0xA5) is page zero. Byte 0x4C is a jump. Every other byte is undecoded, including 0xB5, which has the load operation and group but a different mode.
- R3: An immediate load puts the byte at PC+1 into `acc`. It takes 3 cycles: opcode read, operand read, accumulator write. The next opcode fetch is at PC+2.
- R4: A page-zero load uses the byte at PC+1 as the low address byte and forces the high byte to 0x00. It reads that location in the cycle after the operand arrives and loads the result into `acc`. It takes 4 cycles, and the next opcode fetch is at PC+2.
- R5: Each instruction's first cycle is a single-byte read at PC, and an opcode fetch always has `mem_rd` high with `mem_addr` equal to PC.
- R6: Jump 0x4C reads the target low byte at PC+1 and then the high byte at PC+2. It loads {high, low} into PC with no length step added and leaves `acc` unchanged. It takes 4 cycles.
- R7: An undecoded opcode raises `illegal_op` for exactly one cycle, the second cycle of the instruction, and no memory read takes place in that cycle. It leaves `acc` unchanged, and the next opcode fetch is at PC+1, two cycles after the previous fetch.
- R8: PC is 16 bits wide and wraps modulo 65536. A 2-byte instruction at 0xFFFF reads its operand from 0x0000, and the next opcode fetch is at 0x0001.
- R9: `acc` changes only to the byte that `mem_rdata` presented in the previous cycle, and only after a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory byte address, meaningful while `mem_rd` is high |
| mem_rd | output | 1 | Read strobe; data returns on `mem_rdata` one cycle later |
| mem_rdata | input | 8 | Byte returned for the previous cycle's read |
| acc | output | 8 | Accumulator contents |
| illegal_op | output | 1 | One-cycle pulse when an undecoded opcode is retired |

## Verification
The assertions check the following on every cycle:

- the reset fetch and the clean accumulator after reset;
- that every opcode-fetch cycle reads at PC;
- that a page-zero data read carries a zero high byte;
- that a jump lands PC exactly on the assembled target;
- that the undecoded-opcode pulse lasts one cycle, issues no read and steps PC by one;
- that the accumulator only ever takes the byte returned in the cycle before.

Some behaviours depend on what memory holds, so only the bench's scenarios can show them:

- the cycle count of each instruction form;
- that the right value arrives in the accumulator;
- wrap-around at the top of the address space;
- that each of the 253 undecoded opcodes is classified correctly.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    parameter int AW = 16;
    parameter int DW = 8;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;

    localparam logic [2:0] OP_LOAD   = 3'b101;
    localparam logic [1:0] GRP_ONE   = 2'b01;
    localparam logic [2:0] MODE_IMM  = 3'b010;
    localparam logic [2:0] MODE_PZ   = 3'b001;
    localparam byte_t      OPC_JUMP  = 8'h4C;

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] mode;
        logic [1:0] grp;
    } opfields_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPER1,
        ST_DATA,
        ST_OPER2
    } state_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_LD_IMM,
        K_LD_PZ,
        K_JUMP
    } kind_e;

    function automatic kind_e classify(input byte_t b);
        opfields_t f;
        kind_e     k;
        f = opfields_t'(b);
        k = K_NONE;
        if (b == OPC_JUMP) begin
            k = K_JUMP;
        end else if (f.grp == GRP_ONE && f.op == OP_LOAD) begin
            case (f.mode)
                MODE_IMM: k = K_LD_IMM;
                MODE_PZ:  k = K_LD_PZ;
                default:  k = K_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic addr_t inst_len(input kind_e k);
        case (k)
            K_LD_IMM, K_LD_PZ: return addr_t'(2);
            K_JUMP:            return addr_t'(3);
            default:           return addr_t'(1);
        endcase
    endfunction

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
    import cpu8_pkg::*;
(
    input  byte_t opcode,
    output kind_e kind,
    output addr_t length
);
    always_comb begin
        kind   = classify(opcode);
        length = inst_len(kind);
    end
endmodule

// File: rtl/cpu8_pc.sv
module cpu8_pc
    import cpu8_pkg::*;
#(
    parameter addr_t RESET_PC = addr_t'(16'h0200)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load_en,
    input  addr_t load_val,
    input  logic  step_en,
    input  addr_t step_len,
    output addr_t pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= RESET_PC;
        end else if (load_en) begin
            pc <= load_val;
        end else if (step_en) begin
            pc <= pc + step_len;
        end
    end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter addr_t RESET_PC = addr_t'(16'h0200)
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    input  logic [7:0]  mem_rdata,
    output logic [7:0]  acc,
    output logic        illegal_op
);
    localparam int PAD = AW - DW;

    state_e state_q, state_d;
    kind_e  kind_q, kind_now;
    byte_t  lo_q;
    byte_t  acc_q;
    addr_t  pc_q;
    addr_t  len_now;

    logic   acc_we;
    logic   pc_load, pc_step;
    addr_t  pc_load_val, pc_step_len;

    cpu8_decode dec_i (
        .opcode (mem_rdata),
        .kind   (kind_now),
        .length (len_now)
    );

    cpu8_pc #(.RESET_PC(RESET_PC)) pc_i (
        .clk      (clk),
        .rst      (rst),
        .load_en  (pc_load),
        .load_val (pc_load_val),
        .step_en  (pc_step),
        .step_len (pc_step_len),
        .pc       (pc_q)
    );

    always_comb begin
        state_d     = state_q;
        mem_rd      = 1'b0;
        mem_addr    = pc_q;
        illegal_op  = 1'b0;
        acc_we      = 1'b0;
        pc_load     = 1'b0;
        pc_load_val = pc_q;
        pc_step     = 1'b0;
        pc_step_len = inst_len(kind_q);
        case (state_q)
            ST_FETCH: begin
                mem_rd  = 1'b1;
                state_d = ST_DECODE;
            end
            ST_DECODE: begin
                if (kind_now == K_NONE) begin
                    illegal_op  = 1'b1;
                    pc_step     = 1'b1;
                    pc_step_len = len_now;
                    state_d     = ST_FETCH;
                end else begin
                    mem_rd   = 1'b1;
                    mem_addr = pc_q + addr_t'(1);
                    state_d  = ST_OPER1;
                end
            end
            ST_OPER1: begin
                case (kind_q)
                    K_LD_IMM: begin
                        acc_we  = 1'b1;
                        pc_step = 1'b1;
                        state_d = ST_FETCH;
                    end
                    K_LD_PZ: begin
                        mem_rd   = 1'b1;
                        mem_addr = {{PAD{1'b0}}, mem_rdata};
                        state_d  = ST_DATA;
                    end
                    K_JUMP: begin
                        mem_rd   = 1'b1;
                        mem_addr = pc_q + addr_t'(2);
                        state_d  = ST_OPER2;
                    end
                    default: state_d = ST_FETCH;
                endcase
            end
            ST_DATA: begin
                acc_we  = 1'b1;
                pc_step = 1'b1;
                state_d = ST_FETCH;
            end
            ST_OPER2: begin
                pc_load     = 1'b1;
                pc_load_val = {mem_rdata, lo_q};
                state_d     = ST_FETCH;
            end
            default: state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            kind_q  <= K_NONE;
            lo_q    <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DECODE) kind_q <= kind_now;
            if (state_q == ST_OPER1)  lo_q   <= mem_rdata;
            if (acc_we)               acc_q  <= mem_rdata;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk
    import cpu8_pkg::*;
#(
    parameter addr_t RESET_PC = addr_t'(16'h0200)
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] mem_addr,
    input logic        mem_rd,
    input logic [7:0]  mem_rdata,
    input logic [7:0]  acc,
    input logic        illegal_op,
    input state_e      state_q,
    input kind_e       kind_q,
    input addr_t       pc_q,
    input byte_t       lo_q
);
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc == 8'h00 && mem_rd && mem_addr == RESET_PC && !illegal_op)); // R1

    AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |-> (mem_rd && mem_addr == pc_q)); // R5

    AST_PZ_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPER1 && kind_q == K_LD_PZ) |-> (mem_rd && mem_addr[AW-1:DW] == '0)); // R4

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPER2) |=> (pc_q == {$past(mem_rdata), $past(lo_q)})); // R6

    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst)
        illegal_op |=> !illegal_op); // R7

    AST_ILLEGAL_NO_READ: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> !mem_rd); // R7

    AST_ILLEGAL_STEP: assert property (@(posedge clk) disable iff (rst)
        illegal_op |=> (mem_rd && pc_q == addr_t'($past(pc_q) + addr_t'(1)))); // R7

    AST_ACC_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc) |-> ($past(mem_rd, 2) && acc == $past(mem_rdata))); // R9

endmodule

bind cpu8_core cpu8_core_chk #(.RESET_PC(RESET_PC)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_rdata  (mem_rdata),
    .acc        (acc),
    .illegal_op (illegal_op),
    .state_q    (state_q),
    .kind_q     (kind_q),
    .pc_q       (pc_q),
    .lo_q       (lo_q)
);

// File: tb/cpu8_core_tb_top.sv
module cpu8_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic [7:0]  acc;
    logic        illegal_op;

    logic [7:0]  mem [0:1023];
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    cpu8_core #(.RESET_PC(16'h0200)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_rdata  (mem_rdata),
        .acc        (acc),
        .illegal_op (illegal_op)
    );

    // Behavioural memory: 1 KiB, aliased across the 64 KiB space
    always_ff @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_fetch(input logic [15:0] a, input string req);
        check(mem_rd == 1'b1, req, "fetch strobe", 32'(mem_rd), 32'd1);
        check(mem_addr == a, req, "fetch address", 32'(mem_addr), 32'(a));
    endtask

    task automatic expect_acc(input logic [7:0] v, input string req);
        check(acc == v, req, "accumulator", 32'(acc), 32'(v));
    endtask

    task automatic do_reset(input bit full);
        @(negedge clk);
        rst = 1'b1;
        tick(2);
        if (full) begin
            check(acc == 8'h00, "R1", "acc in reset", 32'(acc), 32'h0);
        end
        rst = 1'b0;
        #1;
        expect_fetch(16'h0200, "R1");
        check(illegal_op == 1'b0, "R1", "illegal_op after reset", 32'(illegal_op), 32'd0);
        if (full) expect_acc(8'h00, "R1");
    endtask

    function automatic logic [7:0] pz_val(input int i);
        return 8'((i * 7 + 3) ^ 8'h5A);
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'hEA;
        mem[10'h000] = 8'hE1;
        mem[10'h001] = 8'h4C; mem[10'h002] = 8'h00; mem[10'h003] = 8'h02;
        mem[10'h010] = 8'hC3;
        mem[10'h0FF] = 8'h77;
        mem[10'h200] = 8'hA9; mem[10'h201] = 8'h5A;
        mem[10'h202] = 8'hA5; mem[10'h203] = 8'h10;
        mem[10'h204] = 8'h02;
        mem[10'h205] = 8'hB5;
        mem[10'h206] = 8'hA9; mem[10'h207] = 8'h00;
        mem[10'h208] = 8'h4C; mem[10'h209] = 8'h00; mem[10'h20A] = 8'h03;
        mem[10'h300] = 8'hA5; mem[10'h301] = 8'hFF;
        mem[10'h302] = 8'h4C; mem[10'h303] = 8'hFF; mem[10'h304] = 8'hFF;
        mem[10'h3FF] = 8'hA9;

        do_reset(1'b1);

        // R3 immediate load
        tick(1);
        check(mem_rd && mem_addr == 16'h0201, "R3", "operand read at PC+1", 32'(mem_addr), 32'h201);
        tick(2);
        expect_fetch(16'h0202, "R3");
        expect_acc(8'h5A, "R3");

        // R4 page-zero load
        tick(2);
        check(mem_rd && mem_addr == 16'h0010, "R4", "page-zero data address", 32'(mem_addr), 32'h10);
        expect_acc(8'h5A, "R4");
        tick(2);
        expect_fetch(16'h0204, "R4");
        expect_acc(8'hC3, "R4");

        // R7 undecoded 0x02
        tick(1);
        check(illegal_op == 1'b1, "R7", "illegal pulse for 02", 32'(illegal_op), 32'd1);
        check(mem_rd == 1'b0, "R7", "no read in illegal cycle", 32'(mem_rd), 32'd0);
        tick(1);
        check(illegal_op == 1'b0, "R7", "pulse length", 32'(illegal_op), 32'd0);
        expect_fetch(16'h0205, "R7");
        expect_acc(8'hC3, "R7");

        // R2 0xB5: load op and group, wrong mode
        tick(1);
        check(illegal_op == 1'b1, "R2", "B5 undecoded", 32'(illegal_op), 32'd1);
        tick(1);
        expect_fetch(16'h0206, "R2");

        tick(3);
        expect_fetch(16'h0208, "R3");
        expect_acc(8'h00, "R3");

        // R6 jump to 0x0300
        tick(1);
        check(mem_rd && mem_addr == 16'h0209, "R6", "jump low byte address", 32'(mem_addr), 32'h209);
        tick(1);
        check(mem_rd && mem_addr == 16'h020A, "R6", "jump high byte address", 32'(mem_addr), 32'h20A);
        tick(2);
        expect_fetch(16'h0300, "R6");
        expect_acc(8'h00, "R6");

        tick(4);
        expect_fetch(16'h0302, "R4");
        expect_acc(8'h77, "R4");

        // R8 wrap at top of address space
        tick(4);
        expect_fetch(16'hFFFF, "R6");
        tick(1);
        check(mem_rd && mem_addr == 16'h0000, "R8", "operand wraps to 0000", 32'(mem_addr), 32'h0);
        tick(2);
        expect_fetch(16'h0001, "R8");
        expect_acc(8'hE1, "R8");
        tick(4);
        expect_fetch(16'h0200, "R6");

        // R7/R2 sweep over every opcode
        for (int op = 0; op < 256; op++) begin
            bit legal;
            legal = (op == 8'hA9) || (op == 8'hA5) || (op == 8'h4C);
            mem[10'h200] = 8'(op);
            do_reset(1'b0);
            tick(1);
            check(illegal_op == !legal, legal ? "R2" : "R7", "opcode class", 32'(op), 32'(!legal));
            if (!legal) begin
                tick(1);
                expect_fetch(16'h0201, "R7");
                expect_acc(8'h00, "R7");
            end
        end

        // R4/R9 sweep over every page-zero location
        for (int i = 0; i < 256; i++) mem[i] = pz_val(i);
        mem[10'h200] = 8'hA5;
        for (int z = 0; z < 256; z++) begin
            mem[10'h201] = 8'(z);
            do_reset(1'b0);
            tick(2);
            check(mem_rd && mem_addr == 16'(z), "R4", "page-zero address", 32'(mem_addr), 32'(z));
            tick(2);
            expect_fetch(16'h0202, "R4");
            check(acc == pz_val(z), "R9", "loaded page-zero byte", 32'(acc), 32'(pz_val(z)));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule